// File: doc/BRIEF.md
# Machine Trap Vector Target Unit

This block keeps the machine-mode trap vector control register. When a trap is taken, it works out the program counter that execution is sent to. Software reads and writes the 32-bit register through a CSR port. The low two bits choose how traps are dispatched, and the upper bits give the base address of the handler area.

Whenever a trap request arrives, the unit uses the register value held in that cycle. One cycle later it presents the redirect address together with a valid strobe.

Dispatch works in one of two modes:
- **Direct mode:** every trap goes to the base address.
- **Vectored mode:** synchronous exceptions still go to the base address. Asynchronous interrupts go to a slot four bytes per cause code above the base. The timer interrupt (cause 7) lands at base + 0x1C, and all external interrupts share cause 11 at base + 0x2C.

The register legalizes whatever is written to it. The mode field can never hold a reserved encoding. Whenever vectored mode is in force, the base is forced onto a 128-byte boundary.

Top module: `tvec_unit`

## Requirements
- R1: After reset the register reads 0 (direct mode, base 0) and the target valid strobe is low.
- R2: Register layout: bits [1:0] are the mode (0 = direct, 1 = vectored, 2 and 3 reserved) and bits [31:2] are the base address bits [31:2]; base bits [1:0] are implicitly zero. A write takes effect on the clock edge of its strobe and is read back from the next cycle; without a write the register holds.
- R3: A write whose bits [1:0] are 2 or 3 keeps the previous mode, while its bits [31:2] are still taken as the new base (subject to R4).
- R4: Whenever the resulting mode is vectored, stored and read base bits [6:2] are zero.
- R5: In direct mode every trap, interrupt (trap_irq = 1) or exception (trap_irq = 0), targets the base address.
- R6: In vectored mode a synchronous exception (trap_irq = 0) targets the base address.
- R7: In vectored mode an interrupt (trap_irq = 1) with cause code c targets base + 4*c; cause 7 gives base + 0x1C, cause 11 gives base + 0x2C.
- R8: tgt_valid is high exactly in the cycle after a cycle with trap_valid high, and tgt_pc in that cycle carries the target.
- R9: A trap in the same cycle as a register write uses the register value from before the write.
- R10: In direct mode base bits [6:2] are stored and read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Current legal register value |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_irq | input | 1 | 1 = asynchronous interrupt, 0 = synchronous exception |
| trap_cause | input | 4 | Cause code of the trap |
| tgt_valid | output | 1 | Redirect target valid |
| tgt_pc | output | 32 | Redirect target address |

## Verification
The bench builds the unit with its defaults: a 32-bit register, 4-bit cause codes and a 128-byte vectored alignment. With these values every cause slot from 0 to 60 bytes fits inside one aligned window, so each of the sixteen slot offsets can be reached. Random write data hits both reserved mode encodings and arbitrary values in base bits [6:2], in both modes. Random overlap of writes and traps exercises the rule that a same-cycle trap sees the old register value.

// File: rtl/tvec_pkg.sv
package tvec_pkg;
  localparam int unsigned MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_DIRECT   = 2'd0,
    MODE_VECTORED = 2'd1,
    MODE_RSVD2    = 2'd2,
    MODE_RSVD3    = 2'd3
  } tvec_mode_e;
endpackage

// File: rtl/tvec_csr.sv
module tvec_csr
  import tvec_pkg::*;
#(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned ALIGN_LG2 = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] rd_data,
  output logic [XLEN-1:0] base_addr,
  output logic            vec_mode
);
  localparam int unsigned BASE_W = XLEN - MODE_W;
  localparam int unsigned CLR_W  = ALIGN_LG2 - MODE_W;

  tvec_mode_e        mode_q;
  logic [BASE_W-1:0] base_q;

  // Keep the current mode when the request is a reserved encoding.
  function automatic tvec_mode_e pick_mode(tvec_mode_e cur, logic [MODE_W-1:0] req);
    if (req == MODE_DIRECT || req == MODE_VECTORED) return tvec_mode_e'(req);
    return cur;
  endfunction

  // Clear the sub-alignment base bits when vectored.
  function automatic logic [BASE_W-1:0] fit_base(logic [BASE_W-1:0] b, logic vec);
    logic [BASE_W-1:0] keep;
    keep = '1;
    keep[CLR_W-1:0] = '0;
    return vec ? (b & keep) : b;
  endfunction

  // Named internal events for the checks.
  logic [MODE_W-1:0] wr_mode_req;
  logic              wr_reserved;
  tvec_mode_e        wr_mode_eff;
  logic [BASE_W-1:0] wr_base_eff;

  assign wr_mode_req = wr_data[MODE_W-1:0];
  assign wr_reserved = wr_en && (wr_mode_req != MODE_DIRECT) && (wr_mode_req != MODE_VECTORED);
  assign wr_mode_eff = pick_mode(mode_q, wr_mode_req);
  assign wr_base_eff = fit_base(wr_data[XLEN-1:MODE_W], wr_mode_eff == MODE_VECTORED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_DIRECT;
      base_q <= '0;
    end else if (wr_en) begin
      mode_q <= wr_mode_eff;
      base_q <= wr_base_eff;
    end
  end

  assign rd_data   = {base_q, mode_q};
  assign base_addr = {base_q, {MODE_W{1'b0}}};
  assign vec_mode  = (mode_q == MODE_VECTORED);

  // R2
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] == 1'b0);

  // R3
  rsvd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reserved |=> rd_data[MODE_W-1:0] == $past(rd_data[MODE_W-1:0]));

  // R4
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_mode |-> base_addr[ALIGN_LG2-1:0] == '0);

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data));
endmodule

// File: rtl/tvec_target.sv
module tvec_target #(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_valid,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [XLEN-1:0]    base_addr,
  input  logic               vec_mode,
  output logic               tgt_valid,
  output logic [XLEN-1:0]    tgt_pc
);
  localparam int unsigned PAD_W = XLEN - CAUSE_W - 2;

  // Base, or base plus one word per cause for vectored interrupts.
  function automatic logic [XLEN-1:0] slot_addr(logic [XLEN-1:0] base, logic vec,
                                                logic irq, logic [CAUSE_W-1:0] cause);
    if (vec && irq) return base + {{PAD_W{1'b0}}, cause, 2'b00};
    return base;
  endfunction

  logic            take_vec;
  logic [XLEN-1:0] slot_pc;

  assign take_vec = trap_valid && vec_mode && trap_irq;
  assign slot_pc  = slot_addr(base_addr, vec_mode, trap_irq, trap_cause);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_valid <= 1'b0;
      tgt_pc    <= '0;
    end else begin
      tgt_valid <= trap_valid;
      if (trap_valid) tgt_pc <= slot_pc;
    end
  end

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> tgt_valid);

  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_valid |=> !tgt_valid);

  // R5
  base_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !(vec_mode && trap_irq)) |=> tgt_pc == $past(base_addr));

  // R7
  slot_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_vec |=> (tgt_pc - $past(base_addr)) == {{PAD_W{1'b0}}, $past(trap_cause), 2'b00});
endmodule

// File: rtl/tvec_unit.sv
module tvec_unit #(
  parameter int unsigned XLEN      = 32,
  parameter int unsigned CAUSE_W   = 4,
  parameter int unsigned ALIGN_LG2 = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_we,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  input  logic               trap_valid,
  input  logic               trap_irq,
  input  logic [CAUSE_W-1:0] trap_cause,
  output logic               tgt_valid,
  output logic [XLEN-1:0]    tgt_pc
);
  logic [XLEN-1:0] base_addr;
  logic            vec_mode;

  tvec_csr #(.XLEN(XLEN), .ALIGN_LG2(ALIGN_LG2)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (csr_we),
    .wr_data   (csr_wdata),
    .rd_data   (csr_rdata),
    .base_addr (base_addr),
    .vec_mode  (vec_mode)
  );

  tvec_target #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_tgt (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_valid (trap_valid),
    .trap_irq   (trap_irq),
    .trap_cause (trap_cause),
    .base_addr  (base_addr),
    .vec_mode   (vec_mode),
    .tgt_valid  (tgt_valid),
    .tgt_pc     (tgt_pc)
  );

  // R9
  same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !trap_irq && csr_we) |=> tgt_pc == {$past(csr_rdata[XLEN-1:2]), 2'b00});
endmodule

// File: tb/tb_tvec_unit.sv
module tb_tvec_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        trap_valid = 1'b0;
  logic        trap_irq = 1'b0;
  logic [3:0]  trap_cause = '0;
  logic        tgt_valid;
  logic [31:0] tgt_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mreg = '0;

  always #10 clk = ~clk;

  tvec_unit dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .trap_valid(trap_valid), .trap_irq(trap_irq),
    .trap_cause(trap_cause), .tgt_valid(tgt_valid), .tgt_pc(tgt_pc)
  );

  // Register value after a write, per R2 R3 R4 R10.
  function automatic logic [31:0] m_write(logic [31:0] old, logic [31:0] wd);
    logic [1:0]  md;
    logic [31:0] b;
    md = (wd[1:0] > 2'd1) ? old[1:0] : wd[1:0];
    b  = {wd[31:2], 2'b00};
    if (md == 2'd1) b = b & ~32'h7F;
    return b | {30'd0, md};
  endfunction

  // Target per R5 R6 R7.
  function automatic logic [31:0] m_target(logic [31:0] r, logic irq, logic [3:0] c);
    logic [31:0] b;
    b = {r[31:2], 2'b00};
    if (r[1:0] == 2'd1 && irq) return b + 32'(c) * 32'd4;
    return b;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check one cycle later.
  task automatic step(logic we, logic [31:0] wd, logic tv, logic irq, logic [3:0] c,
                      string ptag);
    logic [31:0] exp_pc;
    string t;
    csr_we = we; csr_wdata = wd; trap_valid = tv; trap_irq = irq; trap_cause = c;
    exp_pc = m_target(mreg, irq, c);
    if (ptag != "") t = ptag;
    else if (mreg[1:0] == 2'd0) t = "R5";
    else if (!irq) t = "R6";
    else t = "R7";
    @(posedge clk);
    @(negedge clk);
    if (we) mreg = m_write(mreg, wd);
    check(we && wd[1:0] > 2'd1 ? "R3" : (mreg[1:0] == 2'd1 ? "R4" : "R2"), csr_rdata, mreg);
    check("R8", {31'd0, tgt_valid}, {31'd0, tv});
    if (tv) check(t, tgt_pc, exp_pc);
    csr_we = 1'b0; trap_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", csr_rdata, 32'd0);
    check("R1", {31'd0, tgt_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", csr_rdata, 32'd0);
    // vectored, unaligned base bits cleared (R4)
    step(1, 32'h800000FD, 0, 0, 0, "");
    check("R4", csr_rdata, 32'h80000081);
    step(0, 0, 1, 1, 4'd7, "R7");   // timer slot
    check("R7", tgt_pc, 32'h8000009C);
    step(0, 0, 1, 1, 4'd11, "R7");  // external slot
    check("R7", tgt_pc, 32'h800000AC);
    step(0, 0, 1, 0, 4'd11, "R6");
    // reserved mode write keeps vectored, base taken (R3)
    step(1, 32'h12345676, 0, 0, 0, "");
    check("R3", csr_rdata, 32'h12345601);
    // direct mode keeps low base bits (R10)
    step(1, 32'h00001234, 0, 0, 0, "");
    check("R10", csr_rdata, 32'h00001234);
    step(0, 0, 1, 1, 4'd7, "R5");
    step(1, 32'h0000567B, 0, 0, 0, "");
    check("R3", csr_rdata, 32'h00005678);
    // write and trap in one cycle (R9)
    step(1, 32'h40000001, 1, 1, 4'd3, "R9");
    check("R9", tgt_pc, 32'h00005678);
    step(0, 0, 1, 1, 4'd3, "R7");
    check("R7", tgt_pc, 32'h4000000C);
    step(0, 0, 0, 0, 0, "");        // idle, strobe low (R8)
    for (int i = 0; i < 3000; i++) begin
      logic we, tv;
      we = ($urandom % 4) == 0;
      tv = ($urandom % 2) == 0;
      step(we, $urandom, tv, 1'($urandom), 4'($urandom), (we && tv) ? "R9" : "");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule